// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns one character into an asynchronous NRZ frame on a single serial line. A separate rate generator supplies a one-cycle enable pulse per bit period. The frame is one low start bit, then the data bits, then an optional parity bit, then one high stop bit. Three character formats are selectable: eight data bits, seven data bits with a parity bit in the eighth position, and nine data bits. The data bits can go out lowest bit first or highest bit first. The parity bit always comes after the data, whichever order is chosen.

A host presents the character and its configuration and pulses `load` while `busy` is low. The block captures the whole frame in that cycle, so later changes to the inputs do not affect a frame already in progress. `busy` stays high until the enable pulse that ends the stop bit. The line then rests at the mark level until the next accepted load.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1 and `busy` is 0.
- R2: A `load` pulse while `busy` is 0 starts a frame on the same clock edge: `txd` goes to 0 (start bit) and `busy` goes to 1. Each bit of the frame stays on the line until the next `baud_en` pulse.
- R3: `fmt` = 2'b00 sends eight data bits `din[7:0]` and no parity, 10 bit periods in all. `fmt` = 2'b11 behaves exactly like 2'b00.
- R4: `fmt` = 2'b01 sends seven data bits `din[6:0]` and then one parity bit, 10 bit periods in all.
- R5: `fmt` = 2'b10 sends nine data bits `din[8:0]` and no parity, 11 bit periods in all.
- R6: With `msb_first` = 0 the data go out from `din[0]` upward. With `msb_first` = 1 they go out from the highest data bit of the selected format downward.
- R7: The parity bit is computed over the seven transmitted data bits only. With `par_odd` = 0 the count of ones in data plus parity is even; with `par_odd` = 1 it is odd. The parity bit follows the data in both bit orders.
- R8: The last bit of every frame is a 1 (stop bit). `busy` returns to 0 on the `baud_en` pulse that ends the stop bit, and `txd` stays 1 from then on.
- R9: A `load` pulse while `busy` is 1 is ignored. The frame in progress goes on unchanged.
- R10: `din` bits above the data width of the selected format have no effect on the line.
- R11: `din`, `fmt`, `par_odd` and `msb_first` are sampled only when a load is accepted. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_en | input | 1 | One-cycle pulse per bit period |
| load | input | 1 | Request to send the character on `din` |
| din | input | DATA_W | Character, right-aligned |
| fmt | input | 2 | Format: 00 eight bits, 01 seven bits + parity, 10 nine bits, 11 same as 00 |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| msb_first | input | 1 | 1 sends the highest data bit first |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | High while a frame is being sent |

## Verification
The bench builds the block with its default `DATA_W` of 9. This width makes all three formats reachable, including the nine-bit mode, and leaves spare high bits in the seven- and eight-bit modes to show they are ignored. The bench generates `baud_en` every third cycle. Loads therefore arrive at different phases of the enable, including on the same edge as a pulse. The bench also sends loads and input changes in the middle of frames, so that both ignored loads and the sampling of the inputs only at load time are exercised.

// File: rtl/uftx_pkg.sv
package uftx_pkg;
  typedef enum logic [1:0] {
    FMT_OCTET  = 2'b00,
    FMT_SEPT_P = 2'b01,
    FMT_NONET  = 2'b10,
    FMT_ALT8   = 2'b11
  } uftx_fmt_e;
endpackage

// File: rtl/uftx_frame_build.sv
module uftx_frame_build
  import uftx_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int FRAME_W = DATA_W + 2,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  din,
  input  logic [1:0]         fmt,
  input  logic               par_odd,
  input  logic               msb_first,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits
);
  localparam int BASE_W   = DATA_W - 1;
  localparam int NARROW_W = DATA_W - 2;

  uftx_fmt_e sel;
  int        dw;
  logic      par_bit;
  logic      has_par;

  always_comb begin
    sel     = uftx_fmt_e'(fmt);
    has_par = (sel == FMT_SEPT_P);
    case (sel)
      FMT_SEPT_P: dw = NARROW_W;
      FMT_NONET:  dw = DATA_W;
      default:    dw = BASE_W;
    endcase
    par_bit = (^din[NARROW_W-1:0]) ^ par_odd;
    // frame[0] goes out first
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < dw) begin
        frame[1+i] = msb_first ? din[dw-1-i] : din[i];
      end
    end
    if (has_par) frame[1+NARROW_W] = par_bit;
    nbits = CNT_W'(dw + 2 + (has_par ? 1 : 0));
  end
endmodule

// File: rtl/uftx_shifter.sv
module uftx_shifter #(
  parameter int FRAME_W = 11,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               baud_en,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CNT_W-1:0]   nbits,
  output logic               txd,
  output logic               busy
);
  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   left;

  always_ff @(posedge clk) begin
    if (rst) begin
      txd  <= 1'b1;
      busy <= 1'b0;
      sh   <= '1;
      left <= '0;
    end else if (!busy && start) begin
      txd  <= frame[0];
      sh   <= {1'b1, frame[FRAME_W-1:1]};
      left <= nbits - CNT_W'(1);
      busy <= 1'b1;
    end else if (busy && baud_en) begin
      if (left == '0) begin
        busy <= 1'b0;
        txd  <= 1'b1;
      end else begin
        txd  <= sh[0];
        sh   <= {1'b1, sh[FRAME_W-1:1]};
        left <= left - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_en,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        fmt,
  input  logic              par_odd,
  input  logic              msb_first,
  output logic              txd,
  output logic              busy
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;
  logic               start;

  assign start = load & ~busy;

  uftx_frame_build #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_build (
    .din(din), .fmt(fmt), .par_odd(par_odd), .msb_first(msb_first),
    .frame(frame), .nbits(nbits)
  );

  uftx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .start(start), .baud_en(baud_en),
    .frame(frame), .nbits(nbits), .txd(txd), .busy(busy)
  );
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rst,
  input logic baud_en,
  input logic load,
  input logic txd,
  input logic busy
);
  a_r1_idle_mark: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);

  a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd);

  a_r2_hold_between_pulses: assert property (@(posedge clk) disable iff (rst)
    busy && !baud_en |=> $stable(txd));

  a_r8_end_on_pulse: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(baud_en));

  a_r8_stop_high: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(txd));

  a_r9_load_ignored: assert property (@(posedge clk) disable iff (rst)
    busy && load && !baud_en |=> busy);
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk(clk), .rst(rst), .baud_en(baud_en), .load(load), .txd(txd), .busy(busy)
);

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;
  localparam int DATA_W = 9;
  localparam int DIV    = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              baud_en = 1'b0;
  logic              load = 1'b0;
  logic [DATA_W-1:0] din = '0;
  logic [1:0]        fmt = 2'b00;
  logic              par_odd = 1'b0;
  logic              msb_first = 1'b0;
  logic              txd;
  logic              busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit    exp_bit[$];
  string exp_tag[$];
  int    exp_len[$];
  string len_tag[$];

  always #10 clk = ~clk;

  uart_frame_tx #(.DATA_W(DATA_W)) u_uart_frame_tx (
    .clk(clk), .rst(rst), .baud_en(baud_en), .load(load), .din(din),
    .fmt(fmt), .par_odd(par_odd), .msb_first(msb_first),
    .txd(txd), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor and baud pulse generator
  bit busy_q = 1'b0;
  int slots = 0;
  int phase = 0;
  always @(negedge clk) begin
    if (rst) begin
      busy_q  = 1'b0;
      slots   = 0;
      phase   = 0;
      baud_en = 1'b0;
    end else begin
      if ((busy && !busy_q) || (busy_q && baud_en && busy)) begin
        if (exp_bit.size() == 0) begin
          check(1'b0, "R9 unexpected frame", 1, 0);
        end else begin
          bit e;
          string t;
          e = exp_bit.pop_front();
          t = exp_tag.pop_front();
          check(txd == e, t, int'(txd), int'(e));
        end
        slots++;
      end
      if (busy_q && baud_en && !busy) begin
        int l;
        string t;
        check(txd == 1'b1, "R8 line high after frame", int'(txd), 1);
        l = (exp_len.size() != 0) ? exp_len.pop_front() : -1;
        t = (len_tag.size() != 0) ? len_tag.pop_front() : "R9 length";
        check(slots == l, t, slots, l);
        slots = 0;
      end
      busy_q = busy;
      phase = (phase + 1) % DIV;
      baud_en = (phase == 0);
    end
  end

  task automatic send(input logic [8:0] d, input logic [1:0] f, input logic odd,
                      input logic m, input string tag);
    int w;
    bit p;
    w = (f == 2'b01) ? 7 : (f == 2'b10) ? 9 : 8;
    p = odd;
    for (int k = 0; k < 7; k++) p = p ^ d[k];
    exp_bit.push_back(1'b0); exp_tag.push_back({tag, " start"});
    for (int k = 0; k < w; k++) begin
      exp_bit.push_back(m ? d[w-1-k] : d[k]);
      exp_tag.push_back({tag, " data"});
    end
    if (f == 2'b01) begin
      exp_bit.push_back(p); exp_tag.push_back({tag, " R7 parity"});
    end
    exp_bit.push_back(1'b1); exp_tag.push_back({tag, " R8 stop"});
    exp_len.push_back(w + 2 + ((f == 2'b01) ? 1 : 0));
    len_tag.push_back({tag, " length"});
    while (busy) @(negedge clk);
    din = d; fmt = f; par_odd = odd; msb_first = m; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(txd == 1'b1, "R1 reset txd", int'(txd), 1);
    check(busy == 1'b0, "R1 reset busy", int'(busy), 0);

    send(9'h0A5, 2'b00, 1'b0, 1'b0, "R3 R6 8bit lsb");
    send(9'h03C, 2'b00, 1'b0, 1'b1, "R3 R6 8bit msb");
    send(9'h00F, 2'b11, 1'b0, 1'b0, "R3 alt code");
    send(9'h055, 2'b01, 1'b0, 1'b0, "R4 R7 even lsb");
    send(9'h013, 2'b01, 1'b1, 1'b1, "R4 R7 odd msb");
    send(9'h180, 2'b01, 1'b0, 1'b1, "R10 7bit high ignored");
    send(9'h1FF, 2'b00, 1'b1, 1'b0, "R10 8bit top ignored");
    send(9'h1A5, 2'b10, 1'b0, 1'b0, "R5 R6 9bit lsb");
    send(9'h101, 2'b10, 1'b0, 1'b1, "R5 R6 9bit msb");
    wait_idle();
    check(txd == 1'b1 && busy == 1'b0, "R1 idle between", int'({busy, txd}), 1);

    // R9 R11: loads and input changes during a frame
    send(9'h0C3, 2'b01, 1'b1, 1'b0, "R9 R11 base frame");
    repeat (4) @(negedge clk);
    din = 9'h1FF; fmt = 2'b10; msb_first = 1'b1; par_odd = 1'b0; load = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, "R9 busy kept", int'(busy), 1);
    repeat (5) @(negedge clk);
    load = 1'b0;
    wait_idle();
    check(txd == 1'b1 && busy == 1'b0, "R9 no extra frame", int'({busy, txd}), 1);

    for (int n = 0; n < 12; n++) begin
      send(9'((n * 37 + 11) & 9'h1FF), 2'(n % 4), 1'(n % 2), 1'((n / 2) % 2), "R6 R7 sweep");
    end
    wait_idle();
    check(exp_bit.size() == 0, "R2 all bits seen", exp_bit.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule